// File: doc/BRIEF.md
# Multichannel FM Square-Wave Sound Engine

This block runs a bank of square-wave oscillators one after another. Each oscillator keeps its state in two memory cells: a control cell and a phase cell. The control cell holds a 15-bit frequency step and a chaining flag. For every sample frame the engine visits each channel in ascending order. It reads the control cell, then reads the phase cell, then writes the advanced phase back. It also counts how many oscillators sit high on each stereo side.

A new frame starts on a single-cycle `frame_tick`, which the system pulses at the audio sample rate (31.25 kHz in the intended setting). When a frame ends, the two counts are offered as one stereo sample on a valid/ready output.

Loudness is set only by how many channels play the same tone. A chained channel advances by half or by one and a half times its step, and the previous channel's square output selects which. This gives frequency modulation without a multiplier.

Memory requests use a valid/ready handshake. A request stays unchanged until it is accepted. Read data returns later on `mem_rvalid`, and only one read is outstanding at a time.

The sample output follows its own back-pressure rule. `smp_valid` stays high with the sample unchanged until `smp_ready` is seen. If a frame finishes while the previous sample has not been taken, the engine waits before storing the new one, so no sample is lost. A consumer that takes the old sample in the same cycle lets the new sample move in at once.

Top module: `snd_engine`

## Requirements
- R1: After reset, `smp_valid` and `mem_valid` are low and the engine is idle.
- R2: For channel c, the engine makes three accesses in this order: a read at `BASE+2c+1` (control cell), a read at `BASE+2c` (phase cell), and a write at `BASE+2c`. Channels are visited from 0 to NCH-1.
- R3: When control bit 15 is 0, the new phase is the old phase plus control bits [14:0], modulo 2^16.
- R4: When control bit 15 is 1, the step depends on the previous channel's square output. The step is (k>>1) if that output is 0, and k+(k>>1) if it is 1, where k is control bits [14:0]. The sum is taken modulo 2^16.
- R5: A channel's square output is bit 15 of its new phase. For channel 0, the "previous channel" is channel NCH-1 from the prior frame, which counts as 0 after reset.
- R6: `smp_left` equals the number of even-numbered channels whose output is 1 in the frame. `smp_right` equals the same count for odd-numbered channels.
- R7: While `smp_valid` is high and `smp_ready` is low, the sample stays stable. A finished frame waits and does not overwrite it.
- R8: A frame starts only on a `frame_tick` seen while the engine is idle. A tick that arrives during a frame is ignored.
- R9: While `mem_valid` is high and `mem_ready` is low, the address, the write-enable and the write data all stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | Sample-rate strobe that starts a frame |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Cell address |
| mem_wdata | output | DW | Phase to write |
| mem_rdata | input | DW | Read data |
| mem_rvalid | input | 1 | Read data valid, one pulse per read |
| smp_valid | output | 1 | Stereo sample valid |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_left | output | SW | Count of high even channels |
| smp_right | output | SW | Count of high odd channels |

## Verification
The engine can store a finished frame in the same cycle that the consumer takes the previous sample. The bench provokes this by holding `smp_ready` low across a second frame. It then checks two things: the first sample stays put, and the memory already shows the second frame's phases. On release, the second frame's counts must appear in the next cycle. The chaining flag and the carried-over reference for channel 0 also meet in one step. The bench sweeps all chaining masks over several consecutive frames and compares each result with arithmetic expectations.

// File: rtl/snd_pkg.sv
package snd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCTL,
    ST_WCTL,
    ST_RPH,
    ST_WPH,
    ST_WR,
    ST_DONE
  } snd_state_t;
endpackage

// File: rtl/snd_step.sv
module snd_step #(
  parameter int DW    = 16,
  parameter bit FM_EN = 1'b1
) (
  input  logic [DW-1:0] ctl_cell,
  input  logic [DW-1:0] phase,
  input  logic          prev_out,
  output logic [DW-1:0] nphase,
  output logic          out_bit
);
  logic [DW-1:0] k;
  logic [DW-1:0] step;

  assign k = {1'b0, ctl_cell[DW-2:0]};

  generate
    if (FM_EN) begin : g_fm
      always_comb begin
        if (ctl_cell[DW-1])
          step = prev_out ? (k + (k >> 1)) : (k >> 1);
        else
          step = k;
      end
    end else begin : g_plain
      always_comb step = k;
    end
  endgenerate

  assign nphase  = phase + step;
  assign out_bit = nphase[DW-1];
endmodule

// File: rtl/snd_mix.sv
module snd_mix #(
  parameter int NCH = 64,
  parameter int SW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc_en,
  input  logic          acc_odd,
  input  logic          acc_bit,
  input  logic          latch,
  input  logic          smp_ready,
  output logic          smp_valid,
  output logic [SW-1:0] smp_left,
  output logic [SW-1:0] smp_right,
  output logic          slot_free
);
  localparam logic [SW-1:0] HALF = SW'(NCH / 2);

  logic [SW-1:0] cnt_l, cnt_r;

  assign slot_free = !smp_valid || smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_l <= '0;
      cnt_r <= '0;
    end else if (clr) begin
      cnt_l <= '0;
      cnt_r <= '0;
    end else if (acc_en && acc_bit) begin
      if (acc_odd) cnt_r <= cnt_r + 1'b1;
      else         cnt_l <= cnt_l + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
    end else if (latch) begin
      smp_valid <= 1'b1;
      smp_left  <= cnt_l;
      smp_right <= cnt_r;
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  assert_sample_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_left) && $stable(smp_right));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_l <= HALF && cnt_r <= HALF);

  assert_no_lost_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> slot_free);
endmodule

// File: rtl/snd_seq.sv
module snd_seq
  import snd_pkg::*;
#(
  parameter int            NCH    = 64,
  parameter int            DW     = 16,
  parameter int            ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter bit            FM_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic              frame_clr,
  output logic              acc_en,
  output logic              acc_odd,
  output logic              acc_bit,
  output logic              latch,
  input  logic              slot_free
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  snd_state_t    state;
  logic [CW-1:0] ch;
  logic [DW-1:0] ctl_q, nph_q;
  logic          prev_q, outb_q;
  logic [DW-1:0] nphase;
  logic          obit;

  snd_step #(.DW(DW), .FM_EN(FM_EN)) u_step (
    .ctl_cell (ctl_q),
    .phase    (mem_rdata),
    .prev_out (prev_q),
    .nphase   (nphase),
    .out_bit  (obit)
  );

  assign mem_valid = (state == ST_RCTL) || (state == ST_RPH) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = BASE + ADDR_W'({ch, (state == ST_RCTL)});
  assign mem_wdata = nph_q;

  assign frame_clr = (state == ST_IDLE) && frame_tick;
  assign acc_en    = (state == ST_WR) && mem_ready;
  assign acc_odd   = ch[0];
  assign acc_bit   = outb_q;
  assign latch     = (state == ST_DONE) && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ch     <= '0;
      ctl_q  <= '0;
      nph_q  <= '0;
      prev_q <= 1'b0;
      outb_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (frame_tick) begin
          ch    <= '0;
          state <= ST_RCTL;
        end
        ST_RCTL: if (mem_ready) state <= ST_WCTL;
        ST_WCTL: if (mem_rvalid) begin
          ctl_q <= mem_rdata;
          state <= ST_RPH;
        end
        ST_RPH: if (mem_ready) state <= ST_WPH;
        ST_WPH: if (mem_rvalid) begin
          nph_q  <= nphase;
          outb_q <= obit;
          state  <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          prev_q <= outb_q;
          if (ch == LAST) state <= ST_DONE;
          else begin
            ch    <= ch + 1'b1;
            state <= ST_RCTL;
          end
        end
        ST_DONE: if (slot_free) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

  assert_write_to_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> ((mem_addr - BASE) & ADDR_W'(1)) == '0);

  assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_addr) == mem_addr);

  assert_tick_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && frame_tick |=> !frame_clr || (state != ST_IDLE));
endmodule

// File: rtl/snd_engine.sv
module snd_engine #(
  parameter int                NCH    = 64,
  parameter int                DW     = 16,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'hFE00,
  parameter bit                FM_EN  = 1'b1,
  parameter int                SW     = $clog2(NCH / 2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SW-1:0]     smp_left,
  output logic [SW-1:0]     smp_right
);
  logic frame_clr, acc_en, acc_odd, acc_bit, latch, slot_free;

  snd_seq #(
    .NCH(NCH), .DW(DW), .ADDR_W(ADDR_W), .BASE(BASE), .FM_EN(FM_EN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .frame_clr  (frame_clr),
    .acc_en     (acc_en),
    .acc_odd    (acc_odd),
    .acc_bit    (acc_bit),
    .latch      (latch),
    .slot_free  (slot_free)
  );

  snd_mix #(.NCH(NCH), .SW(SW)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (frame_clr),
    .acc_en    (acc_en),
    .acc_odd   (acc_odd),
    .acc_bit   (acc_bit),
    .latch     (latch),
    .smp_ready (smp_ready),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .slot_free (slot_free)
  );

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> !mem_valid);
endmodule

// File: tb/sim_snd_engine.sv
module sim_snd_engine;
  localparam int NCH = 4;
  localparam int SW  = 2;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0;
  logic mem_valid, mem_ready = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic smp_valid, smp_ready = 1'b0;
  logic [SW-1:0] smp_left, smp_right;

  always #10 clk = ~clk;

  snd_engine #(.NCH(NCH), .ADDR_W(16), .BASE(BASE), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right)
  );

  logic [15:0] mem [0:2*NCH-1];
  int cyc = 0, pend = 0, acc_k = 0, seq_err = 0;
  logic [15:0] pdata;
  int n_chk = 0, n_fail = 0;

  // memory model: accepts requests on a stall pattern, returns reads after 1-2 cycles
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rvalid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = pdata;
      end
    end
    mem_ready = 1'b0;
    if (rst_n && mem_valid && pend == 0 && !mem_rvalid && (cyc % 3) != 2) begin
      int c, t, idx;
      c = (acc_k / 3) % NCH;
      t = acc_k % 3;
      if (mem_addr != BASE + 16'(2*c + ((t == 0) ? 1 : 0)) || mem_we != (t == 2))
        seq_err = seq_err + 1;
      acc_k = acc_k + 1;
      idx = int'(mem_addr - BASE) % (2*NCH);
      mem_ready = 1'b1;
      if (mem_we) mem[idx] = mem_wdata;
      else begin
        pdata = mem[idx];
        pend  = 1 + (cyc % 2);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected model
  logic [15:0] ref_ph [0:NCH-1];
  logic        ref_prev = 1'b0;
  int          exp_l, exp_r;

  task automatic model_frame();
    exp_l = 0; exp_r = 0;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] ctl, k, st, np;
      ctl = mem[2*c+1];
      k   = {1'b0, ctl[14:0]};
      if (ctl[15]) st = ref_prev ? (k + (k >> 1)) : (k >> 1);
      else         st = k;
      np = ref_ph[c] + st;
      ref_ph[c] = np;
      ref_prev  = np[15];
      if (np[15]) begin
        if (c % 2 == 0) exp_l++;
        else            exp_r++;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000 && !smp_valid; i++) @(negedge clk);
  endtask

  task automatic take();
    smp_ready = 1'b1;
    @(negedge clk) smp_ready = 1'b0;
  endtask

  task automatic check_mem(input string req);
    for (int c = 0; c < NCH; c++)
      chk(mem[2*c] == ref_ph[c], req, mem[2*c], ref_ph[c]);
  endtask

  task automatic setup(input int combo, input logic [3:0] cmask);
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] kv;
      kv = 16'((combo * 16'h1357 + c * 16'h2E1D + 16'h0123) & 16'h7FFF);
      mem[2*c+1] = {cmask[c], kv[14:0]};
    end
  endtask

  task automatic run_frame(input string req);
    tick();
    wait_valid();
    model_frame();
    chk(smp_valid == 1'b1, req, smp_valid, 1);
    chk(int'(smp_left) == exp_l, "R6 left", smp_left, exp_l);
    chk(int'(smp_right) == exp_r, "R6 right", smp_right, exp_r);
    check_mem(req);
    chk(seq_err == 0, "R2 order", seq_err, 0);
    take();
  endtask

  initial begin
    #2000000;
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int l1, r1;
    for (int c = 0; c < NCH; c++) begin
      mem[2*c]   = 16'(c * 16'h3001);
      mem[2*c+1] = 16'h0;
      ref_ph[c]  = 16'(c * 16'h3001);
    end
    repeat (3) @(negedge clk);
    chk(smp_valid == 1'b0, "R1 smp_valid", smp_valid, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_valid == 1'b0, "R1 idle", mem_valid, 0);

    // R3: unchained, large steps to force wrap
    for (int c = 0; c < NCH; c++) mem[2*c+1] = 16'h7FFF - 16'(c);
    for (int f = 0; f < 4; f++) run_frame("R3 unchained");

    // R4/R5: all chaining masks, several frames each
    for (int m = 0; m < 16; m++) begin
      setup(m, 4'(m));
      for (int f = 0; f < 3; f++) run_frame("R4 chained");
    end
    // R5: all chained with max step so carried reference for channel 0 matters
    for (int c = 0; c < NCH; c++) mem[2*c+1] = 16'hFFFF;
    for (int f = 0; f < 6; f++) run_frame("R5 carry ref");

    // R7: hold off consumer across a second frame
    setup(7, 4'b0101);
    tick();
    wait_valid();
    model_frame();
    l1 = exp_l; r1 = exp_r;
    tick();
    repeat (300) @(negedge clk);
    model_frame();
    chk(smp_valid == 1'b1, "R7 held valid", smp_valid, 1);
    chk(int'(smp_left) == l1, "R7 held left", smp_left, l1);
    chk(int'(smp_right) == r1, "R7 held right", smp_right, r1);
    check_mem("R7 second frame ran");
    take();
    chk(smp_valid == 1'b1, "R7 next sample", smp_valid, 1);
    chk(int'(smp_left) == exp_l, "R7 next left", smp_left, exp_l);
    chk(int'(smp_right) == exp_r, "R7 next right", smp_right, exp_r);
    take();

    // R8: second tick during a frame is ignored
    setup(3, 4'b1010);
    tick();
    repeat (4) @(negedge clk);
    tick();
    wait_valid();
    model_frame();
    chk(int'(smp_left) == exp_l, "R8 left", smp_left, exp_l);
    take();
    repeat (300) @(negedge clk);
    chk(smp_valid == 1'b0, "R8 no extra sample", smp_valid, 0);
    check_mem("R8 single step");
    chk(seq_err == 0, "R2 order", seq_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule